// File: doc/BRIEF.md
# Single-Register I2C Control Target

This block is an I2C target that owns one 8-bit system register and has no sub-address pointer. A controller writes one byte to set six control bits. It reads the same byte back, and the two lowest bit positions of that byte carry live fault flags. The decoded control bits leave the block as individual outputs. These outputs select the enable, the voltage level, the level compensation, the tone enable, the tone gating and the current-limit mode of a power stage.

The 7-bit target address is a base value plus a 2-bit strap selection, so four of these blocks can share one bus. SCL and SDA are oversampled by the system clock through a two-flop synchroniser. START, STOP and bit edges are derived from the synchronised levels. The block changes SDA only while SCL is low, and it never stretches the clock.

A power-good input controls the power-on hold-off. While power-good is low, the control bits are held at zero and the interface ignores all bus traffic. When power is restored, the register stays at zero until the controller writes it.

Top module: `lnb_ctrl_i2c`

## Requirements
- R1: The target address is BASE_ADDR (default 7'h08) plus `addr_sel_i`, which gives 0x08 to 0x0B. A matching address byte is acknowledged by pulling SDA low during the ninth clock. A non-matching address gets no ACK, and the block ignores the rest of the traffic until the next START.
- R2: An address byte whose R/W bit (bit 0) is 0 starts a write. Each following data byte is acknowledged and updates the control bits.
- R3: Data bits 7..2 map to `ilim_static_o`, `tone_gate_o`, `tone_en_o`, `llc_o`, `vsel_o` and `en_o`, in that order. Data bits 1..0 are discarded.
- R4: When a write carries several data bytes, the last byte received before STOP determines the control outputs.
- R5: An address byte with R/W = 1 starts a read. The register byte is shifted out MSB first, and SDA driven by the block changes only while SCL is low.
- R6: The read byte carries the control bits in bits 7..2, the over-temperature input in bit 1 and the overload input in bit 0. Each flag reads 1 when its input is high.
- R7: During a read, a controller ACK on the ninth clock makes the block send the register byte again. A NACK makes it release SDA and stay silent until the next START.
- R8: A repeated START is treated as a new address phase, so a write can be followed by a read without a STOP in between.
- R9: While `pgood_i` is low, all control outputs are forced to 0 within 3 clock cycles and no bus traffic is acknowledged. After `pgood_i` returns high, the control outputs stay 0 until the next write.
- R10: After reset, all control outputs are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired value) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Address strap, added to the base address |
| pgood_i | input | 1 | Supply good; low holds the block in lockout |
| ovt_i | input | 1 | Over-temperature fault input |
| ovl_i | input | 1 | Overload fault input |
| ilim_static_o | output | 1 | Register bit 7: static current limit selected |
| tone_gate_o | output | 1 | Register bit 6: tone gating mode |
| tone_en_o | output | 1 | Register bit 5: tone forced on |
| llc_o | output | 1 | Register bit 4: line-loss compensation |
| vsel_o | output | 1 | Register bit 3: high voltage level |
| en_o | output | 1 | Register bit 2: power stage enable |

## Verification
The synchroniser and the edge detector put every reaction to a bus edge 3 to 4 clocks behind the edge. This covers the ACK drive, the next read bit and the release of SDA. The bench therefore holds each SCL phase for two 8-clock quarter periods and samples SDA in the middle of the high phase, well after the block has settled. Control outputs change one clock after the falling edge of the eighth data bit is detected, so the bench checks them only after STOP. A drop of `pgood_i` reaches the outputs after three clocks, and the bench waits six before it checks. A monitor flags any change of the SDA drive while SCL is high.

// File: rtl/lnb_i2c_pkg.sv
package lnb_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } bus_st_e;

  // byte positions of register fields
  localparam int B_ILIM  = 7;
  localparam int B_TGATE = 6;
  localparam int B_TONE  = 5;
  localparam int B_LLC   = 4;
  localparam int B_VSEL  = 3;
  localparam int B_EN    = 2;
  localparam int B_OTF   = 1;
  localparam int B_OLF   = 0;
  localparam int CTRL_LSB = 2;
endpackage

// File: rtl/lnb_sync.sv
module lnb_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= INIT;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= INIT;
        else         q <= g_stg[s-1].q;
    end
  end

  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/lnb_bus_cond.sv
module lnb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_s_i;
  assign scl_fall_o = scl_q && !scl_s_i;
  // SDA edges with SCL held high
  assign start_o    = scl_q && scl_s_i && sda_q && !sda_s_i;
  assign stop_o     = scl_q && scl_s_i && !sda_q && sda_s_i;
endmodule

// File: rtl/lnb_i2c_engine.sv
module lnb_i2c_engine
  import lnb_i2c_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lock_i,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                sda_s_i,
  input  logic [ADDR_W-1:0]   dev_addr_i,
  input  logic [ADDR_W:0]     rd_byte_i,
  output logic                sda_oe_o,
  output logic                wr_stb_o,
  output logic [ADDR_W:0]     wr_byte_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  bus_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rw;
  logic              m_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe_o <= 1'b0;
      wr_stb_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      if (lock_i) begin
        st       <= ST_IDLE;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise_i) begin
              sh  <= {sh[BYTE_W-2:0], sda_s_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == CNT_FULL) begin
              if (st == ST_WDAT) begin
                wr_stb_o <= 1'b1;
                sda_oe_o <= 1'b1;
                st       <= ST_WACK;
              end else if (sh[BYTE_W-1:1] == dev_addr_i) begin
                rw       <= sh[0];
                sda_oe_o <= 1'b1;
                st       <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (rw) begin
                tx       <= {rd_byte_i[BYTE_W-2:0], 1'b0};
                sda_oe_o <= !rd_byte_i[BYTE_W-1];
                st       <= ST_RDAT;
              end else begin
                sda_oe_o <= 1'b0;
                st       <= ST_WDAT;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt      <= '0;
              st       <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise_i) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt == CNT_FULL) begin
                sda_oe_o <= 1'b0;
                st       <= ST_RACK;
              end else begin
                sda_oe_o <= !tx[BYTE_W-1];
                tx       <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              m_ack <= !sda_s_i;
            end else if (scl_fall_i) begin
              if (m_ack) begin
                tx       <= {rd_byte_i[BYTE_W-2:0], 1'b0};
                sda_oe_o <= !rd_byte_i[BYTE_W-1];
                cnt      <= '0;
                st       <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // shift register is stable while the strobe is high
  assign wr_byte_o = sh;
endmodule

// File: rtl/lnb_sys_reg.sv
module lnb_sys_reg #(
  parameter int CTRL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              wr_stb_i,
  input  logic [CTRL_W-1:0] wr_ctrl_i,
  input  logic              ovt_s_i,
  input  logic              ovl_s_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CTRL_W+1:0] rd_byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_o <= '0;
    else if (lock_i)   ctrl_o <= '0;
    else if (wr_stb_i) ctrl_o <= wr_ctrl_i;
  end

  assign rd_byte_o = {ctrl_o, ovt_s_i, ovl_s_i};
endmodule

// File: rtl/lnb_ctrl_i2c.sv
module lnb_ctrl_i2c
  import lnb_i2c_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h08,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] addr_sel_i,
  input  logic       pgood_i,
  input  logic       ovt_i,
  input  logic       ovl_i,
  output logic       ilim_static_o,
  output logic       tone_gate_o,
  output logic       tone_en_o,
  output logic       llc_o,
  output logic       vsel_o,
  output logic       en_o
);
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CTRL_W = BYTE_W - CTRL_LSB;
  localparam int NSYNC  = 5;

  logic [NSYNC-1:0] raw_in, syn;
  logic scl_s, sda_s, pgood_s, ovt_s, ovl_s, lock;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic [CTRL_W-1:0] ctrl;
  logic [ADDR_W-1:0] dev_addr;

  assign raw_in = {scl_i, sda_i, pgood_i, ovt_i, ovl_i};

  lnb_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .INIT(5'b11000)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(syn)
  );

  assign {scl_s, sda_s, pgood_s, ovt_s, ovl_s} = syn;
  assign lock     = !pgood_s;
  assign dev_addr = BASE_ADDR + {{(ADDR_W-2){1'b0}}, addr_sel_i};

  lnb_bus_cond u_cond (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  lnb_i2c_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk_i, .rst_ni,
    .lock_i(lock),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_s_i(sda_s),
    .dev_addr_i(dev_addr),
    .rd_byte_i(rd_byte),
    .sda_oe_o,
    .wr_stb_o(wr_stb),
    .wr_byte_o(wr_byte)
  );

  lnb_sys_reg #(.CTRL_W(CTRL_W)) u_reg (
    .clk_i, .rst_ni,
    .lock_i(lock),
    .wr_stb_i(wr_stb),
    .wr_ctrl_i(wr_byte[BYTE_W-1:CTRL_LSB]),
    .ovt_s_i(ovt_s), .ovl_s_i(ovl_s),
    .ctrl_o(ctrl),
    .rd_byte_o(rd_byte)
  );

  assign ilim_static_o = ctrl[B_ILIM  - CTRL_LSB];
  assign tone_gate_o   = ctrl[B_TGATE - CTRL_LSB];
  assign tone_en_o     = ctrl[B_TONE  - CTRL_LSB];
  assign llc_o         = ctrl[B_LLC   - CTRL_LSB];
  assign vsel_o        = ctrl[B_VSEL  - CTRL_LSB];
  assign en_o          = ctrl[B_EN    - CTRL_LSB];
endmodule

// File: rtl/lnb_ctrl_i2c_chk.sv
module lnb_ctrl_i2c_chk #(
  parameter int CTRL_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pgood_i,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              lock_i,
  input logic              wr_stb_i,
  input logic [CTRL_W-1:0] wr_ctrl_i,
  input logic [CTRL_W-1:0] ctrl_i
);
  // R9
  lock_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pgood_i && $past(!pgood_i) && $past(!pgood_i, 2)) |=> (ctrl_i == '0));

  // R9
  lock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pgood_i && $past(!pgood_i) && $past(!pgood_i, 2)) |=> !sda_oe_o);

  // R2
  wr_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !lock_i) |=> (ctrl_i == $past(wr_ctrl_i)));

  // R5
  drive_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
endmodule

bind lnb_ctrl_i2c lnb_ctrl_i2c_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .pgood_i(pgood_i),
  .scl_i(scl_i),
  .sda_oe_o(sda_oe_o),
  .lock_i(lock),
  .wr_stb_i(wr_stb),
  .wr_ctrl_i(wr_byte[BYTE_W-1:CTRL_LSB]),
  .ctrl_i(ctrl)
);

// File: tb/lnb_ctrl_i2c_bench.sv
module lnb_ctrl_i2c_bench;
  localparam int Q = 8;  // clocks per quarter bus period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic pgood = 1'b1, ovt = 1'b0, ovl = 1'b0;
  logic sda_oe, sda_bus;
  logic ilim, tgate, tone, llc, vsel, en;
  int checks = 0, errors = 0, drive_viol = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  lnb_ctrl_i2c u_lnb_ctrl_i2c (
    .clk_i(clk), .rst_ni(rst_n),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .pgood_i(pgood),
    .ovt_i(ovt), .ovl_i(ovl),
    .ilim_static_o(ilim), .tone_gate_o(tgate), .tone_en_o(tone),
    .llc_o(llc), .vsel_o(vsel), .en_o(en)
  );

  // {sel, write data, {ovt,ovl}, expected read byte}
  localparam logic [19:0] VEC [6] = '{
    {2'd0, 8'hFF, 2'b00, 8'hFC},
    {2'd1, 8'hA5, 2'b01, 8'hA5},
    {2'd2, 8'h5A, 2'b10, 8'h5A},
    {2'd3, 8'h03, 2'b11, 8'h03},
    {2'd2, 8'h84, 2'b00, 8'h84},
    {2'd0, 8'h7E, 2'b11, 8'h7F}
  };

  // R5: SDA drive must hold while SCL is high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) drive_viol++;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(!ack);
  endtask

  function automatic logic [5:0] outs();
    return {ilim, tgate, tone, llc, vsel, en};
  endfunction

  initial begin
    logic a, b;
    logic [7:0] d;
    logic [6:0] addr;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 outputs", outs(), 6'd0);
    chk("R10 sda released", sda_oe, 1'b0);

    // table walk: R1 R2 R3 R6
    for (int v = 0; v < 6; v++) begin
      addr_sel = VEC[v][19:18];
      {ovt, ovl} = VEC[v][9:8];
      addr = 7'h08 + {5'd0, VEC[v][19:18]};
      bus_start();
      wr_byte({addr, 1'b0}, a);
      chk("R1 address ack", a, 1'b1);
      wr_byte(VEC[v][17:10], a);
      chk("R2 data ack", a, 1'b1);
      bus_stop();
      chk("R3 outputs", outs(), VEC[v][7:2]);
      bus_start();
      wr_byte({addr, 1'b1}, a);
      chk("R5 read address ack", a, 1'b1);
      rd_byte(1'b0, d);
      bus_stop();
      chk("R6 read byte", d, VEC[v][7:0]);
    end
    ovt = 1'b0; ovl = 1'b0;

    // R1 non-matching address: no ack, data ignored
    addr_sel = 2'd0;
    bus_start();
    wr_byte({7'h0C, 1'b0}, a);
    chk("R1 mismatch nack", a, 1'b0);
    wr_byte(8'h00, a);
    chk("R1 mismatch data ignored ack", a, 1'b0);
    bus_stop();
    chk("R1 mismatch outputs kept", outs(), 6'b011111);

    // R4 multi-byte write keeps the last byte
    bus_start();
    wr_byte({7'h08, 1'b0}, a);
    wr_byte(8'hFC, a);
    wr_byte(8'h10, a);
    wr_byte(8'h88, a);
    chk("R4 last byte ack", a, 1'b1);
    bus_stop();
    chk("R4 last byte kept", outs(), 6'b100010);

    // R8 write then repeated START and read
    bus_start();
    wr_byte({7'h08, 1'b0}, a);
    wr_byte(8'h24, a);
    bus_start();
    wr_byte({7'h08, 1'b1}, a);
    chk("R8 readdress ack", a, 1'b1);
    rd_byte(1'b0, d);
    bus_stop();
    chk("R8 read after restart", d, 8'h24);

    // R7 repeated copies while acked, release after NACK
    ovt = 1'b1;
    bus_start();
    wr_byte({7'h08, 1'b1}, a);
    rd_byte(1'b1, d);
    chk("R7 copy 1", d, 8'h26);
    rd_byte(1'b1, d);
    chk("R7 copy 2", d, 8'h26);
    rd_byte(1'b0, d);
    chk("R7 copy 3", d, 8'h26);
    get_bit(b);
    chk("R7 released after nack", b, 1'b1);
    bus_stop();
    ovt = 1'b0;

    // R9 lockout
    bus_start();
    wr_byte({7'h08, 1'b0}, a);
    wr_byte(8'hFF, a);
    bus_stop();
    chk("R9 preset", outs(), 6'h3F);
    pgood = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 cleared by lockout", outs(), 6'd0);
    bus_start();
    wr_byte({7'h08, 1'b0}, a);
    chk("R9 deaf in lockout", a, 1'b0);
    wr_byte(8'hFF, a);
    bus_stop();
    chk("R9 no write in lockout", outs(), 6'd0);
    pgood = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 stays zero after recovery", outs(), 6'd0);
    bus_start();
    wr_byte({7'h08, 1'b1}, a);
    chk("R9 responsive after recovery", a, 1'b1);
    rd_byte(1'b0, d);
    bus_stop();
    chk("R9 read zero after recovery", d, 8'h00);

    chk("R5 sda steady while scl high", drive_viol, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule